// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block produces the enable pulses that pace a UART's serial shift engines. Software writes one 32-bit rate word over a plain register write port. The word carries a 12-bit increment (the mantissa) and a 4-bit exponent. The exponent selects a power-of-two wrap value for a phase accumulator, and the accumulator adds the mantissa on every clock. Each time the running sum reaches the wrap value, the block emits an oversampling tick and keeps the remainder.

The oversampling tick runs at `clk * M / 2^(11+N)`, which is sixteen times the serial bit rate `clk * M / 2^(15+N)`. A second strobe marks every sixteenth oversampling tick, which gives the receiver and transmitter a bit-rate enable as well. Software normally picks the largest exponent for which `clk / 2^(N+4)` still reaches the target rate. That choice keeps the mantissa at or below 2^11, so the tick rate stays fine-grained.

All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready handshake and applies no back-pressure. A write is accepted in the cycle it is presented.

Top module: `frac_baud_gen`

## Requirements
- R1: A write stores `cfg_wdata[11:0]` as the mantissa M and `cfg_wdata[15:12]` as the exponent N. `cfg_rdata` returns these 16 bits in the same positions, and bits 31:16 always read as zero.
- R2: When M ≤ 2^(11+N), the number of `os_tick` pulses in the first W cycles after a write equals floor(W·M / 2^(11+N)).
- R3: When M is 0, `os_tick` and `bit_tick` stay low.
- R4: When M ≥ 2^(11+N), the increment is limited to 2^(11+N), and `os_tick` is high on every cycle after the write cycle.
- R5: A write restarts the phase: the accumulator and the sixteen-tick counter are cleared and both outputs are low in the following cycle. The first tick then comes ceil(2^(11+N)/M) cycles after the write.
- R6: `bit_tick` is high only together with `os_tick`, on the 16th, 32nd, 48th and later oversampling ticks counted from the last write or reset.
- R7: Each oversampling tick lasts one clock. When 2·M ≤ 2^(11+N), two ticks never occur in adjacent cycles.
- R8: While `rst_n` is low, the rate word, both outputs and all internal state are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the rate word |
| cfg_wdata | input | 32 | Rate word: mantissa [11:0], exponent [15:12] |
| cfg_rdata | output | 32 | Stored rate word, upper bits zero |
| os_tick | output | 1 | One-cycle oversampling enable (16x bit rate) |
| bit_tick | output | 1 | One-cycle bit-rate enable, every 16th os_tick |

## Verification
The assertions check on every cycle the properties that follow from the current rate word alone. These are:
- the bit strobe appears only together with an oversampling tick;
- a zero mantissa gives silence;
- an oversized mantissa saturates the output to a tick on every cycle;
- a write clears the outputs;
- a slow rate cannot produce back-to-back ticks;
- reset holds everything at zero.

The exact tick count over a window, the position of the first tick after a restart and the alignment of the first bit strobe depend on accumulated history. Only the bench scenarios can show these, by counting pulses against floor(W·M/2^(11+N)) for several mantissa and exponent pairs.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int MANT_W     = 12;
  localparam int EXP_W      = 4;
  localparam int BASE_SHIFT = 11;
  localparam int OVS        = 16;
  localparam int DATA_W     = 32;
endpackage

// File: rtl/fbg_rate_reg.sv
module fbg_rate_reg #(
  parameter int MANT_W = fbg_pkg::MANT_W,
  parameter int EXP_W  = fbg_pkg::EXP_W,
  parameter int DATA_W = fbg_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [MANT_W-1:0] mant,
  output logic [EXP_W-1:0]  expo,
  output logic [DATA_W-1:0] rdata
);
  localparam int FIELD_W = MANT_W + EXP_W;

  logic [FIELD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wdata[FIELD_W-1:0];
  end

  assign mant  = word_q[MANT_W-1:0];
  assign expo  = word_q[FIELD_W-1:MANT_W];
  assign rdata = DATA_W'(word_q);
endmodule

// File: rtl/fbg_phase_accum.sv
module fbg_phase_accum #(
  parameter int MANT_W     = fbg_pkg::MANT_W,
  parameter int EXP_W      = fbg_pkg::EXP_W,
  parameter int BASE_SHIFT = fbg_pkg::BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic              wrap
);
  // Room for the largest modulus plus one increment.
  localparam int ACC_W = BASE_SHIFT + (1 << EXP_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] modulus;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] sum;

  always_comb begin
    modulus = ACC_W'(1) << (int'(expo) + BASE_SHIFT);
    step    = (ACC_W'(mant) > modulus) ? modulus : ACC_W'(mant);
    sum     = acc_q + step;
    wrap    = (sum >= modulus);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (restart) acc_q <= '0;
    else if (wrap)    acc_q <= sum - modulus;
    else              acc_q <= sum;
  end
endmodule

// File: rtl/fbg_tick_shaper.sv
module fbg_tick_shaper #(
  parameter int OVS = fbg_pkg::OVS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic wrap,
  output logic os_tick,
  output logic bit_tick
);
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else if (restart) begin
      cnt_q    <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      os_tick  <= wrap;
      bit_tick <= wrap && (cnt_q == LAST);
      if (wrap) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int MANT_W     = fbg_pkg::MANT_W,
  parameter int EXP_W      = fbg_pkg::EXP_W,
  parameter int BASE_SHIFT = fbg_pkg::BASE_SHIFT,
  parameter int OVS        = fbg_pkg::OVS,
  parameter int DATA_W     = fbg_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              os_tick,
  output logic              bit_tick
);
  logic [MANT_W-1:0] mant;
  logic [EXP_W-1:0]  expo;
  logic              wrap;

  fbg_rate_reg #(.MANT_W(MANT_W), .EXP_W(EXP_W), .DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .mant(mant), .expo(expo), .rdata(cfg_rdata)
  );

  fbg_phase_accum #(.MANT_W(MANT_W), .EXP_W(EXP_W), .BASE_SHIFT(BASE_SHIFT)) u_acc (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr_en),
    .mant(mant), .expo(expo), .wrap(wrap)
  );

  fbg_tick_shaper #(.OVS(OVS)) u_shp (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr_en), .wrap(wrap),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int MANT_W     = fbg_pkg::MANT_W,
  parameter int EXP_W      = fbg_pkg::EXP_W,
  parameter int BASE_SHIFT = fbg_pkg::BASE_SHIFT,
  parameter int DATA_W     = fbg_pkg::DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              os_tick,
  input logic              bit_tick
);
  localparam int MW = BASE_SHIFT + (1 << EXP_W) + 1;

  logic [MW-1:0] m_val;
  logic [MW-1:0] mod_val;

  assign m_val   = MW'(cfg_rdata[MANT_W-1:0]);
  assign mod_val = MW'(1) << (int'(cfg_rdata[MANT_W+EXP_W-1:MANT_W]) + BASE_SHIFT);

  // R6
  bit_with_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  // R3
  zero_mant_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_val == '0) |=> !os_tick);

  // R4
  saturate_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en && (m_val >= mod_val)) ##1 !cfg_wr_en |-> os_tick);

  // R5
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (!os_tick && !bit_tick));

  // R7
  no_adjacent_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && !cfg_wr_en && ((m_val << 1) <= mod_val)) |=> !os_tick);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!os_tick && !bit_tick && cfg_rdata == '0));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:MANT_W+EXP_W] == '0);
endmodule

bind frac_baud_gen fbg_checker #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .BASE_SHIFT(BASE_SHIFT), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rdata(cfg_rdata),
  .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int WATCHDOG = 100000;

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] win;
    logic [31:0] exp_os;
    logic [31:0] exp_bit;
  } vec_t;

  // word = {exponent[15:12], mantissa[11:0]}; expected os = floor(W*M/2^(11+N)), bit = os/16
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0400, 32'd64,   32'd32,   32'd2},   // R2 half rate
    '{32'h0000_07FF, 32'd2048, 32'd2047, 32'd127}, // R2 largest usual mantissa
    '{32'h0000_0800, 32'd40,   32'd40,   32'd2},   // R4 M equals modulus
    '{32'h0000_1003, 32'd8192, 32'd6,    32'd0},   // R2 N=1 slow
    '{32'h0000_25DC, 32'd4096, 32'd750,  32'd46},  // R2 N=2, M=1500
    '{32'h0000_3000, 32'd500,  32'd0,    32'd0},   // R3 M=0
    '{32'h0000_0FFF, 32'd20,   32'd20,   32'd1},   // R4 clamped
    '{32'h0000_F7FF, 32'd1000, 32'd0,    32'd0}    // R2 N=15 huge modulus
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        os_tick;
  logic        bit_tick;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic run_win(input int unsigned w, output int unsigned nos,
                         output int unsigned nbit, output int unsigned first_bit);
    nos = 0; nbit = 0; first_bit = 0;
    for (int unsigned k = 1; k <= w; k++) begin
      @(negedge clk);
      if (os_tick) nos++;
      if (bit_tick) begin
        nbit++;
        if (first_bit == 0) first_bit = k;
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned nos, nbit, fb;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 os_tick in reset", {31'b0, os_tick}, 32'd0);
    chk("R8 rdata in reset", cfg_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 bit_tick after reset", {31'b0, bit_tick}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      write_word(VECS[i].word);
      chk("R1 readback", cfg_rdata, VECS[i].word);
      chk("R5 outputs low after write", {30'b0, os_tick, bit_tick}, 32'd0);
      run_win(VECS[i].win, nos, nbit, fb);
      chk("R2/R3/R4 os tick count", nos, VECS[i].exp_os);
      chk("R6 bit tick count", nbit, VECS[i].exp_bit);
    end

    // R1 upper bits discarded
    write_word(32'hABCD_5123);
    chk("R1 upper bits read zero", cfg_rdata, 32'h0000_5123);

    // R5 restart: M=1024,N=0 after 5 cycles residue is 1024; rewrite must restart phase
    write_word(32'h0000_0400);
    run_win(5, nos, nbit, fb);
    write_word(32'h0000_0400);
    @(negedge clk);
    chk("R5 no tick one cycle after restart", {31'b0, os_tick}, 32'd0);
    @(negedge clk);
    chk("R5 first tick at cycle 2", {31'b0, os_tick}, 32'd1);
    @(negedge clk);
    chk("R7 tick lasts one clock", {31'b0, os_tick}, 32'd0);

    // R6 sub-counter restart: tick every cycle, first bit strobe at cycle 16
    write_word(32'h0000_0800);
    run_win(10, nos, nbit, fb);
    write_word(32'h0000_0800);
    run_win(20, nos, nbit, fb);
    chk("R6 first bit strobe cycle", fb, 32'd16);
    chk("R6 single strobe in 20 ticks", nbit, 32'd1);

    // R8 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 rdata cleared by reset", cfg_rdata, 32'd0);
    chk("R8 ticks cleared by reset", {30'b0, os_tick, bit_tick}, 32'd0);
    rst_n = 1'b1;
    run_win(10, nos, nbit, fb);
    chk("R3 no ticks after reset with M=0", nos, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule